// File: doc/BRIEF.md
# APB Address-Decoding Slave Multiplexer

This block connects one APB4 master to a configurable number of APB4 peripherals. Each peripheral port has its own address-base and address-mask inputs, so the address map can be set by wiring or changed at run time. The master's select and address are compared against every port's window. At most one peripheral select is raised. That peripheral's ready, error and read-data inputs are returned to the master.

The block holds no registers. Every output is a combinational function of the current inputs. Bus phases, wait states and the write path (direction, enable, write data, strobes, protection) are not handled here; those signals go straight from the master to every peripheral. The master only uses the returned read data on reads (direction low). On writes the data is still routed but the master ignores it.

Internally a route status is derived from the inputs: `ROUTE_IDLE` when the master select is low, `ROUTE_HIT` when some port matches, and `ROUTE_MISS` when the master select is high and no port matches. These are combinational states, not stored states. The status changes with the inputs alone: `ROUTE_IDLE` goes to `ROUTE_HIT` or `ROUTE_MISS` when the master select rises, and any status returns to `ROUTE_IDLE` when the master select falls. `ROUTE_HIT` and `ROUTE_MISS` swap when the address or the map changes.

Top module: `apbx_route`

## Requirements
- R1: Port n matches when (address AND mask[n]) equals (base[n] AND mask[n]). Base bits outside the mask have no effect. A mask of all zeros matches every address.
- R2: A peripheral select output is high only when the master select is high and that port matches the address.
- R3: When several ports match, only the lowest-numbered matching port is selected. At most one select output is ever high.
- R4: With a port selected, the master ready output equals that port's ready input.
- R5: With a port selected, the master error output equals that port's error input. Unused error inputs are expected to be tied low.
- R6: With a port selected, the master read data equals that port's read-data input. The master uses it only on reads.
- R7: When the master select is high and no port matches, all peripheral selects are low, master ready is 1, master error is 1 and master read data is 0.
- R8: When the master select is low, all peripheral selects are low, master read data is 0, ready is 1 and error is 0.
- R9: The response inputs of ports that are not selected have no effect on any master output.
- R10: The block contains no storage. Outputs settle from the current inputs alone, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_sel | input | 1 | Master peripheral select |
| mst_addr | input | ADDR_W | Master address |
| mst_rdata | output | DATA_W | Read data returned to the master |
| mst_ready | output | 1 | Transfer ready returned to the master |
| mst_err | output | 1 | Transfer error returned to the master |
| slv_sel | output | N_PORTS | One select per peripheral (bit n = port n) |
| slv_rdata | input | N_PORTS*DATA_W | Read data of each peripheral, port n at bits [n*DATA_W +: DATA_W] |
| slv_ready | input | N_PORTS | Ready of each peripheral |
| slv_err | input | N_PORTS | Error of each peripheral |
| slv_base | input | N_PORTS*ADDR_W | Address base of each port, port n at bits [n*ADDR_W +: ADDR_W] |
| slv_mask | input | N_PORTS*ADDR_W | Address mask of each port, same packing as the base |

## Verification
A four-port, four-bit-address build is swept over every address, with the master select both low and high, under three address maps. The first map has disjoint quarter windows, which separates a plain decode from a wrong bit-slice. The second has overlapping windows, including a match-all port, which shows whether the lowest index wins. The third puts nonzero base bits outside the mask and leaves holes, which exposes a base that is not masked and exercises the miss response. Response inputs vary with the address. Unselected ports are then scrambled, to show the multiplexer reads only the granted port.

// File: rtl/apbx_pkg.sv
package apbx_pkg;

    // Combinational route status derived from select and match results
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_HIT  = 2'd1,
        ROUTE_MISS = 2'd2
    } route_e;

endpackage

// File: rtl/apbx_match.sv
module apbx_match #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_PORTS*ADDR_W-1:0] base,
    input  logic [N_PORTS*ADDR_W-1:0] mask,
    output logic [N_PORTS-1:0]        hit
);

    // One window comparator per port
    for (genvar p = 0; p < N_PORTS; p++) begin : g_win
        logic [ADDR_W-1:0] m_q;
        assign m_q    = mask[p*ADDR_W +: ADDR_W];
        assign hit[p] = ((addr & m_q) == (base[p*ADDR_W +: ADDR_W] & m_q));
    end

endmodule

// File: rtl/apbx_pick.sv
module apbx_pick #(
    parameter int N_PORTS = 8
) (
    input  logic [N_PORTS-1:0] req,
    output logic [N_PORTS-1:0] grant,
    output logic               any
);

    // Fixed priority: lowest index wins
    always_comb begin
        logic taken;
        grant = '0;
        taken = 1'b0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        any = taken;
    end

endmodule

// File: rtl/apbx_resp.sv
module apbx_resp
    import apbx_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8
) (
    input  route_e                    route,
    input  logic [N_PORTS-1:0]        grant,
    input  logic [N_PORTS*DATA_W-1:0] rdata_in,
    input  logic [N_PORTS-1:0]        ready_in,
    input  logic [N_PORTS-1:0]        err_in,
    output logic [DATA_W-1:0]         rdata_out,
    output logic                      ready_out,
    output logic                      err_out
);

    logic [DATA_W-1:0] pick_data;
    logic              pick_rdy;
    logic              pick_err;

    // AND-OR selection over the one-hot grant
    always_comb begin
        pick_data = '0;
        pick_rdy  = 1'b0;
        pick_err  = 1'b0;
        for (int i = 0; i < N_PORTS; i++) begin
            pick_data = pick_data | (rdata_in[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
            pick_rdy  = pick_rdy  | (ready_in[i] & grant[i]);
            pick_err  = pick_err  | (err_in[i]   & grant[i]);
        end
    end

    always_comb begin
        unique case (route)
            ROUTE_IDLE: begin
                rdata_out = '0;
                ready_out = 1'b1;
                err_out   = 1'b0;
            end
            ROUTE_HIT: begin
                rdata_out = pick_data;
                ready_out = pick_rdy;
                err_out   = pick_err;
            end
            ROUTE_MISS: begin
                rdata_out = '0;
                ready_out = 1'b1;
                err_out   = 1'b1;
            end
            default: begin
                rdata_out = '0;
                ready_out = 1'b1;
                err_out   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/apbx_route.sv
module apbx_route
    import apbx_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input  logic                      mst_sel,
    input  logic [ADDR_W-1:0]         mst_addr,
    output logic [DATA_W-1:0]         mst_rdata,
    output logic                      mst_ready,
    output logic                      mst_err,
    output logic [N_PORTS-1:0]        slv_sel,
    input  logic [N_PORTS*DATA_W-1:0] slv_rdata,
    input  logic [N_PORTS-1:0]        slv_ready,
    input  logic [N_PORTS-1:0]        slv_err,
    input  logic [N_PORTS*ADDR_W-1:0] slv_base,
    input  logic [N_PORTS*ADDR_W-1:0] slv_mask
);

    localparam int DATA_BYTES = DATA_W / 8;

    if (DATA_BYTES * 8 != DATA_W || DATA_W == 0) begin : g_bad_width
        initial $fatal(1, "apbx_route: DATA_W must be a whole number of bytes");
    end

    logic [N_PORTS-1:0] hit;
    logic [N_PORTS-1:0] grant;
    logic               any_hit;
    route_e             route;

    apbx_match #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_match (
        .addr (mst_addr),
        .base (slv_base),
        .mask (slv_mask),
        .hit  (hit)
    );

    apbx_pick #(.N_PORTS(N_PORTS)) u_pick (
        .req   (hit),
        .grant (grant),
        .any   (any_hit)
    );

    // Route status
    always_comb begin
        if (!mst_sel)     route = ROUTE_IDLE;
        else if (any_hit) route = ROUTE_HIT;
        else              route = ROUTE_MISS;
    end

    assign slv_sel = grant & {N_PORTS{mst_sel}};

    apbx_resp #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_resp (
        .route     (route),
        .grant     (grant),
        .rdata_in  (slv_rdata),
        .ready_in  (slv_ready),
        .err_in    (slv_err),
        .rdata_out (mst_rdata),
        .ready_out (mst_ready),
        .err_out   (mst_err)
    );

endmodule

// File: rtl/apbx_route_chk.sv
module apbx_route_chk #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8
) (
    input logic                      mst_sel,
    input logic [ADDR_W-1:0]         mst_addr,
    input logic [DATA_W-1:0]         mst_rdata,
    input logic                      mst_ready,
    input logic                      mst_err,
    input logic [N_PORTS-1:0]        slv_sel,
    input logic [N_PORTS*DATA_W-1:0] slv_rdata,
    input logic [N_PORTS-1:0]        slv_ready,
    input logic [N_PORTS-1:0]        slv_err,
    input logic [N_PORTS*ADDR_W-1:0] slv_base,
    input logic [N_PORTS*ADDR_W-1:0] slv_mask
);

    function automatic logic in_win(input int k, input logic [ADDR_W-1:0] a,
                                    input logic [N_PORTS*ADDR_W-1:0] b,
                                    input logic [N_PORTS*ADDR_W-1:0] m);
        return ((a ^ b[k*ADDR_W +: ADDR_W]) & m[k*ADDR_W +: ADDR_W]) == '0;
    endfunction

    always_comb begin
        if (!$isunknown({mst_sel, mst_addr, mst_rdata, mst_ready, mst_err, slv_sel,
                         slv_rdata, slv_ready, slv_err, slv_base, slv_mask})) begin
            // R3
            one_sel_chk: assert ($onehot0(slv_sel));
            // R8
            idle_quiet_chk: assert (mst_sel || (slv_sel == '0 && mst_rdata == '0 &&
                                    mst_ready && !mst_err));
            // R7
            miss_resp_chk: assert (!mst_sel || slv_sel != '0 ||
                                   (mst_ready && mst_err && mst_rdata == '0));
            for (int k = 0; k < N_PORTS; k++) begin
                if (slv_sel[k]) begin
                    // R2
                    sel_match_chk: assert (mst_sel && in_win(k, mst_addr, slv_base, slv_mask));
                    // R4
                    ready_pass_chk: assert (mst_ready == slv_ready[k]);
                    // R5
                    err_pass_chk: assert (mst_err == slv_err[k]);
                    // R6
                    data_pass_chk: assert (mst_rdata == slv_rdata[k*DATA_W +: DATA_W]);
                    for (int j = 0; j < k; j++) begin
                        // R3
                        low_first_chk: assert (!in_win(j, mst_addr, slv_base, slv_mask));
                    end
                end
            end
        end
    end

endmodule

bind apbx_route apbx_route_chk #(
    .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_route_chk (
    .mst_sel   (mst_sel),
    .mst_addr  (mst_addr),
    .mst_rdata (mst_rdata),
    .mst_ready (mst_ready),
    .mst_err   (mst_err),
    .slv_sel   (slv_sel),
    .slv_rdata (slv_rdata),
    .slv_ready (slv_ready),
    .slv_err   (slv_err),
    .slv_base  (slv_base),
    .slv_mask  (slv_mask)
);

// File: tb/apbx_route_bench.sv
module apbx_route_bench;

    localparam int NP = 4;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic                 mst_sel;
    logic [AW-1:0]        mst_addr;
    logic [DW-1:0]        mst_rdata;
    logic                 mst_ready;
    logic                 mst_err;
    logic [NP-1:0]        slv_sel;
    logic [NP*DW-1:0]     slv_rdata;
    logic [NP-1:0]        slv_ready;
    logic [NP-1:0]        slv_err;
    logic [NP*AW-1:0]     slv_base;
    logic [NP*AW-1:0]     slv_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    apbx_route #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u_apbx_route (
        .mst_sel(mst_sel), .mst_addr(mst_addr), .mst_rdata(mst_rdata),
        .mst_ready(mst_ready), .mst_err(mst_err), .slv_sel(slv_sel),
        .slv_rdata(slv_rdata), .slv_ready(slv_ready), .slv_err(slv_err),
        .slv_base(slv_base), .slv_mask(slv_mask)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_map(input logic [NP*AW-1:0] b, input logic [NP*AW-1:0] m);
        slv_base = b;
        slv_mask = m;
    endtask

    // Expected index of the selected port, -1 when none
    function automatic int exp_idx(input logic [AW-1:0] a);
        for (int k = 0; k < NP; k++)
            if ((a & slv_mask[k*AW +: AW]) == (slv_base[k*AW +: AW] & slv_mask[k*AW +: AW]))
                return k;
        return -1;
    endfunction

    task automatic sweep_map(input int seed);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                int e;
                @(negedge clk);
                mst_sel  = s[0];
                mst_addr = a[AW-1:0];
                for (int k = 0; k < NP; k++)
                    slv_rdata[k*DW +: DW] = DW'(8'h21 * (k + 1) + a * 3 + seed);
                slv_ready = NP'(a ^ seed ^ 5);
                slv_err   = NP'((a >> 1) ^ seed ^ 3);
                #1;
                e = exp_idx(a[AW-1:0]);
                if (!s[0]) begin
                    chk(slv_sel == '0, "R8 sel idle", 64'(slv_sel), 0);
                    chk(mst_rdata == '0 && mst_ready && !mst_err, "R8 idle response",
                        {mst_rdata, mst_ready, mst_err}, 64'h2);
                end else if (e < 0) begin
                    chk(slv_sel == '0, "R7 sel on miss", 64'(slv_sel), 0);
                    chk(mst_rdata == '0 && mst_ready && mst_err, "R7 miss response",
                        {mst_rdata, mst_ready, mst_err}, 64'h3);
                end else begin
                    logic [DW-1:0] d;
                    d = slv_rdata[e*DW +: DW];
                    chk(slv_sel == NP'(1 << e), "R1 R2 R3 select", 64'(slv_sel), 64'(1 << e));
                    chk(mst_ready == slv_ready[e], "R4 ready", 64'(mst_ready), 64'(slv_ready[e]));
                    chk(mst_err == slv_err[e], "R5 error", 64'(mst_err), 64'(slv_err[e]));
                    chk(mst_rdata == d, "R6 read data", 64'(mst_rdata), 64'(d));
                    // R9: scramble every other port's responses, output must hold
                    for (int k = 0; k < NP; k++)
                        if (k != e) slv_rdata[k*DW +: DW] = ~slv_rdata[k*DW +: DW];
                    slv_ready = slv_ready ^ ~NP'(1 << e);
                    slv_err   = slv_err   ^ ~NP'(1 << e);
                    #1;
                    chk(mst_rdata == d && mst_ready == slv_ready[e] && mst_err == slv_err[e],
                        "R9 unselected ignored", {mst_rdata, mst_ready, mst_err},
                        {d, slv_ready[e], slv_err[e]});
                end
            end
        end
    endtask

    initial begin
        mst_sel = 1'b0; mst_addr = '0; slv_rdata = '1; slv_ready = '0; slv_err = '1;
        slv_base = '0; slv_mask = '0;
        #1;
        // R8 / R10: settled idle outputs with no clock edge yet
        chk(slv_sel == '0 && mst_rdata == '0 && mst_ready && !mst_err,
            "R10 initial idle", {slv_sel, mst_rdata, mst_ready, mst_err}, 64'h2);
        // Disjoint quarters
        set_map({4'hC, 4'h8, 4'h4, 4'h0}, {4'hC, 4'hC, 4'hC, 4'hC});
        sweep_map(1);
        // Overlaps: port0 0-7, port1 all, port2 4-7, port3 only F
        set_map({4'hF, 4'h4, 4'h0, 4'h0}, {4'hF, 4'hC, 4'h0, 4'h8});
        sweep_map(2);
        // R1 base bits outside mask, with holes
        set_map({4'hB, 4'hA, 4'h9, 4'h7}, {4'hF, 4'hF, 4'hF, 4'h8});
        sweep_map(3);
        // R10: address change alone, no edge, updates select at once
        #1;
        mst_sel = 1'b1; mst_addr = 4'h9; #1;
        chk(slv_sel == 4'b0010, "R10 follows addr", 64'(slv_sel), 64'h2);
        mst_addr = 4'hC; #1;
        chk(slv_sel == '0 && mst_err, "R10 follows addr miss", {slv_sel, mst_err}, 64'h1);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule